// File: doc/BRIEF.md
# Coprocessor Escape-Instruction Snooper

This block lets a coprocessor that sits beside a host CPU find and capture its own instructions without decoding its own fetch stream. It keeps a private copy of the host's instruction prefetch queue. That copy is filled from the host's code-fetch cycles and drained under the two queue-status pins the host drives. Every instruction whose first byte carries the escape prefix is flagged. The three low bits of that byte are joined with the following addressing byte to form an 11-bit coprocessor opcode.

When the addressing byte selects a memory operand, the host performs one dummy operand read. The snooper lifts the effective address from that cycle. For a store, or for a load longer than one 16-bit word, it then issues a one-cycle DMA request that carries the address, the direction and the number of words. The DMA engine, the arithmetic and bus arbitration sit outside this block.

Top module: `esc_snoop`

## Requirements
- R1: The mirror queue is a FIFO of DEPTH (default 6) bytes. A byte is written on each cycle with `fetch_stb` high, and a byte is removed from the head when `qstat` is 01 or 11 and the queue is not empty. A write and a removal may happen in the same cycle. After reset all output strobes are low.
- R2: When the queue holds DEPTH bytes at the start of a cycle, a fetch in that cycle is dropped, even if a byte is removed in the same cycle.
- R3: `qstat` encoding: 00 idle, 01 first byte of an instruction taken, 10 queue flushed, 11 later byte taken. A flush empties the queue, and a fetch in the flush cycle is dropped. A flush also abandons a pending addressing byte.
- R4: `esc_seen` pulses for one cycle, the cycle after a first-byte removal (qstat 01) whose byte has bits [7:3] equal to 11011. Bytes removed with qstat 11, and other first bytes, never raise it.
- R5: After an escape byte, the next later-byte removal raises `op_valid` for one cycle with `opcode` = {escape bits [2:0], addressing byte}. `op_mem` is high when addressing byte bits [7:6] are not 11.
- R6: For a memory-operand instruction, the first `opr_rd_stb` from the `op_valid` cycle onward latches `opr_addr` into `ea` and pulses `addr_valid` the next cycle. Operand reads are ignored for register-form instructions or when no instruction is pending.
- R7: Addressing byte bit 5 set marks a store. At address capture the block raises `dma_req` with `dma_write`=1 and `dma_len` equal to the operand length in words.
- R8: The operand length comes from escape bits [1:0]: 00→1, 01→2, 10→4, 11→5 words. A load longer than one word raises `dma_req` with `dma_write`=0, `dma_len` = length−1 and `dma_addr` = the latched address. A one-word load raises no request.
- R9: A new first-byte removal abandons both a pending addressing byte and a pending operand capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_stb | input | 1 | Host code-fetch cycle completes this cycle |
| fetch_byte | input | 8 | Byte fetched by the host |
| qstat | input | 2 | Host queue status |
| opr_rd_stb | input | 1 | Host operand read cycle this cycle |
| opr_addr | input | AW | Address of the operand read |
| esc_seen | output | 1 | Escape first byte detected |
| op_valid | output | 1 | Opcode strobe |
| opcode | output | 11 | Captured coprocessor opcode |
| op_mem | output | 1 | Opcode uses a memory operand |
| addr_valid | output | 1 | Effective address captured |
| ea | output | AW | Captured effective address |
| dma_req | output | 1 | DMA request strobe |
| dma_write | output | 1 | Request is a store |
| dma_addr | output | AW | DMA start address |
| dma_len | output | 3 | Words to transfer |

## Verification
A fetch and a queue removal can fall in the same cycle, and so can a fetch and a flush. The bench fills the queue to capacity, then in one cycle removes a byte and offers an escape byte. The correct outcome is that the fetch is dropped. It judges this at the ports: after the remaining bytes are drained, one more first-byte removal must raise no `esc_seen`. The flush case is judged the same way. A scoreboard holds every expected strobe with its value and flags any strobe that was not expected.

// File: rtl/esc_snoop_pkg.sv
package esc_snoop_pkg;

    localparam logic [4:0] ESC_PATTERN = 5'b11011;

    typedef enum logic [1:0] {
        QS_IDLE  = 2'b00,
        QS_FIRST = 2'b01,
        QS_FLUSH = 2'b10,
        QS_LATER = 2'b11
    } qstat_e;

    typedef enum logic {
        DEC_IDLE  = 1'b0,
        DEC_MODRM = 1'b1
    } dec_state_e;

    typedef struct packed {
        logic [2:0] esc;
        logic [7:0] modrm;
    } cop_opcode_t;

    function automatic logic is_escape(input logic [7:0] b);
        return b[7:3] == ESC_PATTERN;
    endfunction

    function automatic logic is_mem_form(input logic [7:0] modrm);
        return modrm[7:6] != 2'b11;
    endfunction

    function automatic logic is_store(input logic [7:0] modrm);
        return modrm[5];
    endfunction

    function automatic logic [2:0] operand_words(input logic [2:0] esc);
        case (esc[1:0])
            2'b00:   return 3'd1;
            2'b01:   return 3'd2;
            2'b10:   return 3'd4;
            default: return 3'd5;
        endcase
    endfunction

endpackage

// File: rtl/esc_mirror_q.sv
module esc_mirror_q
    import esc_snoop_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       fetch_stb,
    input  logic [7:0] fetch_byte,
    input  logic [1:0] qstat,
    output logic       pop_first,
    output logic       pop_later,
    output logic       flush,
    output logic [7:0] head_byte
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

    logic [7:0]    mem [DEPTH];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;
    logic          push_ok, pop_ok, not_empty;

    assign not_empty = count != '0;
    assign flush     = qstat == QS_FLUSH;
    assign pop_first = (qstat == QS_FIRST) && not_empty;
    assign pop_later = (qstat == QS_LATER) && not_empty;
    assign pop_ok    = pop_first || pop_later;
    assign push_ok   = fetch_stb && (count != FULL_CNT) && !flush;
    assign head_byte = mem[rd_ptr];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                mem[wr_ptr] <= fetch_byte;
                wr_ptr      <= bump(wr_ptr);
            end
            if (pop_ok) rd_ptr <= bump(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    a_r1_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);
    a_r2_full_drop: assert property (@(posedge clk) disable iff (rst)
        (count == FULL_CNT && fetch_stb && !pop_ok && !flush) |=> count == FULL_CNT);
    a_r3_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> count == '0);
endmodule

// File: rtl/esc_decode.sv
module esc_decode
    import esc_snoop_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        pop_first,
    input  logic        pop_later,
    input  logic        flush,
    input  logic [7:0]  head_byte,
    output logic        esc_seen,
    output logic        op_valid,
    output cop_opcode_t opcode,
    output logic        op_mem
);
    dec_state_e state;
    logic [2:0] esc_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= DEC_IDLE;
            esc_bits <= '0;
            esc_seen <= 1'b0;
            op_valid <= 1'b0;
            opcode   <= '0;
            op_mem   <= 1'b0;
        end else begin
            esc_seen <= 1'b0;
            op_valid <= 1'b0;
            if (pop_first) begin
                if (is_escape(head_byte)) begin
                    esc_seen <= 1'b1;
                    esc_bits <= head_byte[2:0];
                    state    <= DEC_MODRM;
                end else begin
                    state <= DEC_IDLE;
                end
            end else if (pop_later && state == DEC_MODRM) begin
                op_valid     <= 1'b1;
                opcode.esc   <= esc_bits;
                opcode.modrm <= head_byte;
                op_mem       <= is_mem_form(head_byte);
                state        <= DEC_IDLE;
            end else if (flush) begin
                state <= DEC_IDLE;
            end
        end
    end

    a_r4_esc_from_first: assert property (@(posedge clk) disable iff (rst)
        esc_seen |-> $past(pop_first));
    a_r5_op_one_cycle: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> !op_valid);
    a_r5_op_from_later: assert property (@(posedge clk) disable iff (rst)
        op_valid |-> $past(pop_later));
endmodule

// File: rtl/esc_opr_capture.sv
module esc_opr_capture
    import esc_snoop_pkg::*;
#(
    parameter int AW = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          op_valid,
    input  cop_opcode_t   opcode,
    input  logic          op_mem,
    input  logic          new_instr,
    input  logic          opr_rd_stb,
    input  logic [AW-1:0] opr_addr,
    output logic          addr_valid,
    output logic [AW-1:0] ea,
    output logic          dma_req,
    output logic          dma_write,
    output logic [AW-1:0] dma_addr,
    output logic [2:0]    dma_len
);
    logic        armed;
    cop_opcode_t held_op, live_op;
    logic        live, accept;
    logic [2:0]  words;
    logic        store;

    assign live    = armed || (op_valid && op_mem);
    assign live_op = armed ? held_op : opcode;
    assign accept  = opr_rd_stb && live;
    assign words   = operand_words(live_op.esc);
    assign store   = is_store(live_op.modrm);

    always_ff @(posedge clk) begin
        if (rst) begin
            armed      <= 1'b0;
            held_op    <= '0;
            addr_valid <= 1'b0;
            ea         <= '0;
            dma_req    <= 1'b0;
            dma_write  <= 1'b0;
            dma_addr   <= '0;
            dma_len    <= '0;
        end else begin
            addr_valid <= 1'b0;
            dma_req    <= 1'b0;
            if (accept) begin
                armed      <= 1'b0;
                addr_valid <= 1'b1;
                ea         <= opr_addr;
                dma_addr   <= opr_addr;
                dma_write  <= store;
                if (store) begin
                    dma_req <= 1'b1;
                    dma_len <= words;
                end else if (words > 3'd1) begin
                    dma_req <= 1'b1;
                    dma_len <= words - 3'd1;
                end
            end else if (new_instr) begin
                armed <= 1'b0;
            end else if (op_valid && op_mem) begin
                armed   <= 1'b1;
                held_op <= opcode;
            end
        end
    end

    a_r6_addr_after_read: assert property (@(posedge clk) disable iff (rst)
        addr_valid |-> $past(opr_rd_stb));
    a_r8_dma_with_addr: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> addr_valid && dma_addr == ea);
    a_r7_len_nonzero: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> dma_len != 3'd0);
endmodule

// File: rtl/esc_snoop.sv
module esc_snoop
    import esc_snoop_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int AW    = 20
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          fetch_stb,
    input  logic [7:0]    fetch_byte,
    input  logic [1:0]    qstat,
    input  logic          opr_rd_stb,
    input  logic [AW-1:0] opr_addr,
    output logic          esc_seen,
    output logic          op_valid,
    output logic [10:0]   opcode,
    output logic          op_mem,
    output logic          addr_valid,
    output logic [AW-1:0] ea,
    output logic          dma_req,
    output logic          dma_write,
    output logic [AW-1:0] dma_addr,
    output logic [2:0]    dma_len
);
    logic        pop_first, pop_later, flush;
    logic [7:0]  head_byte;
    cop_opcode_t op_s;

    esc_mirror_q #(.DEPTH(DEPTH)) u_queue (
        .clk(clk), .rst(rst),
        .fetch_stb(fetch_stb), .fetch_byte(fetch_byte), .qstat(qstat),
        .pop_first(pop_first), .pop_later(pop_later),
        .flush(flush), .head_byte(head_byte)
    );

    esc_decode u_decode (
        .clk(clk), .rst(rst),
        .pop_first(pop_first), .pop_later(pop_later),
        .flush(flush), .head_byte(head_byte),
        .esc_seen(esc_seen), .op_valid(op_valid),
        .opcode(op_s), .op_mem(op_mem)
    );

    esc_opr_capture #(.AW(AW)) u_capture (
        .clk(clk), .rst(rst),
        .op_valid(op_valid), .opcode(op_s), .op_mem(op_mem),
        .new_instr(pop_first),
        .opr_rd_stb(opr_rd_stb), .opr_addr(opr_addr),
        .addr_valid(addr_valid), .ea(ea),
        .dma_req(dma_req), .dma_write(dma_write),
        .dma_addr(dma_addr), .dma_len(dma_len)
    );

    assign opcode = op_s;
endmodule

// File: tb/esc_snoop_tb_top.sv
module esc_snoop_tb_top;
    localparam int AW = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          fetch_stb = 1'b0;
    logic [7:0]    fetch_byte = '0;
    logic [1:0]    qstat = 2'b00;
    logic          opr_rd_stb = 1'b0;
    logic [AW-1:0] opr_addr = '0;
    logic          esc_seen, op_valid, op_mem, addr_valid, dma_req, dma_write;
    logic [10:0]   opcode;
    logic [AW-1:0] ea, dma_addr;
    logic [2:0]    dma_len;

    int checks = 0;
    int errors = 0;

    logic [11:0]     exp_op[$];
    logic [AW-1:0]   exp_ea[$];
    logic [AW+3:0]   exp_dma[$];
    int              exp_esc = 0;

    always #2 clk = ~clk;

    esc_snoop #(.DEPTH(6), .AW(AW)) dut_i (
        .clk(clk), .rst(rst),
        .fetch_stb(fetch_stb), .fetch_byte(fetch_byte), .qstat(qstat),
        .opr_rd_stb(opr_rd_stb), .opr_addr(opr_addr),
        .esc_seen(esc_seen), .op_valid(op_valid), .opcode(opcode), .op_mem(op_mem),
        .addr_valid(addr_valid), .ea(ea),
        .dma_req(dma_req), .dma_write(dma_write), .dma_addr(dma_addr), .dma_len(dma_len)
    );

    task automatic check(input string tag, input logic ok, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Monitor: pops scoreboard entries as strobes appear
    initial forever begin
        @(posedge clk);
        #1;
        if (!rst) begin
            if (esc_seen) begin
                check("R4 esc_seen", exp_esc > 0, 1, exp_esc > 0);
                if (exp_esc > 0) exp_esc--;
            end
            if (op_valid) begin
                if (exp_op.size() == 0) check("R5 unexpected op_valid", 1'b0, {op_mem, opcode}, 0);
                else begin
                    logic [11:0] e;
                    e = exp_op.pop_front();
                    check("R5 opcode", {op_mem, opcode} == e, {op_mem, opcode}, e);
                end
            end
            if (addr_valid) begin
                if (exp_ea.size() == 0) check("R6 unexpected addr_valid", 1'b0, ea, 0);
                else begin
                    logic [AW-1:0] e;
                    e = exp_ea.pop_front();
                    check("R6 ea", ea == e, ea, e);
                end
            end
            if (dma_req) begin
                if (exp_dma.size() == 0) check("R7/R8 unexpected dma_req", 1'b0, {dma_write, dma_len, dma_addr}, 0);
                else begin
                    logic [AW+3:0] e;
                    e = exp_dma.pop_front();
                    check("R7/R8 dma", {dma_write, dma_len, dma_addr} == e, {dma_write, dma_len, dma_addr}, e);
                end
            end
        end
    end

    task automatic cyc(input logic fs, input logic [7:0] fb, input logic [1:0] q,
                       input logic rs, input logic [AW-1:0] ra);
        @(negedge clk);
        fetch_stb = fs; fetch_byte = fb; qstat = q; opr_rd_stb = rs; opr_addr = ra;
        @(posedge clk);
        #1;
        fetch_stb = 1'b0; qstat = 2'b00; opr_rd_stb = 1'b0;
    endtask

    task automatic fetch(input logic [7:0] b);
        cyc(1'b1, b, 2'b00, 1'b0, '0);
    endtask

    task automatic pop(input logic [1:0] q);
        cyc(1'b0, 8'h00, q, 1'b0, '0);
    endtask

    task automatic opr_read(input logic [AW-1:0] a);
        cyc(1'b0, 8'h00, 2'b00, 1'b1, a);
    endtask

    task automatic drained(input string tag);
        pop(2'b00);
        pop(2'b00);
        check({tag, " pending strobes"},
              exp_op.size() == 0 && exp_ea.size() == 0 && exp_dma.size() == 0 && exp_esc == 0,
              exp_op.size() + exp_ea.size() + exp_dma.size() + exp_esc, 0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        // R1 reset state
        check("R1 reset strobes", {esc_seen, op_valid, addr_valid, dma_req} == 4'b0,
              {esc_seen, op_valid, addr_valid, dma_req}, 0);

        // R5 register form; R6 operand read ignored
        fetch(8'hD9); fetch(8'hC0);
        exp_esc++; pop(2'b01);
        exp_op.push_back({1'b0, 11'h1C0}); pop(2'b11);
        opr_read(20'h0ABCD);
        drained("R5 R6 register form");

        // R4 non-escape first byte, escape byte as later byte
        fetch(8'h90); fetch(8'hD8);
        pop(2'b01); pop(2'b11);
        drained("R4 no escape");

        // R6 one-word load, no DMA (R8)
        fetch(8'hD8); fetch(8'h06);
        exp_esc++; pop(2'b01);
        exp_op.push_back({1'b1, 11'h006}); pop(2'b11);
        exp_ea.push_back(20'h12345); opr_read(20'h12345);
        drained("R6 R8 one-word load");

        // R8 four-word load, request for remaining 3 words
        fetch(8'hDA); fetch(8'h46);
        exp_esc++; pop(2'b01);
        exp_op.push_back({1'b1, 11'h246}); pop(2'b11);
        pop(2'b00);
        exp_ea.push_back(20'h2F00A);
        exp_dma.push_back({1'b0, 3'd3, 20'h2F00A}); opr_read(20'h2F00A);
        drained("R8 long load");

        // R7 five-word store
        fetch(8'hDB); fetch(8'h2E);
        exp_esc++; pop(2'b01);
        exp_op.push_back({1'b1, 11'h32E}); pop(2'b11);
        exp_ea.push_back(20'hFFFF0);
        exp_dma.push_back({1'b1, 3'd5, 20'hFFFF0}); opr_read(20'hFFFF0);
        drained("R7 store");

        // R2 full queue drops fetch; pop on empty does nothing
        for (int i = 0; i < 6; i++) fetch(8'h90);
        fetch(8'hD9);
        for (int i = 0; i < 6; i++) pop(2'b01);
        pop(2'b01);
        drained("R2 full drop");

        // R2 full queue with same-cycle pop and fetch: fetch dropped
        for (int i = 0; i < 6; i++) fetch(8'h90);
        cyc(1'b1, 8'hD9, 2'b01, 1'b0, '0);
        for (int i = 0; i < 5; i++) pop(2'b01);
        pop(2'b01);
        drained("R2 full pop+fetch");

        // R1 pop and fetch in the same cycle when not full: both happen
        fetch(8'h90);
        cyc(1'b1, 8'hD9, 2'b01, 1'b0, '0);
        fetch(8'hC1);
        exp_esc++; pop(2'b01);
        exp_op.push_back({1'b0, 11'h1C1}); pop(2'b11);
        drained("R1 concurrent");

        // R3 flush empties queue and drops same-cycle fetch
        fetch(8'hD9); fetch(8'hD9);
        cyc(1'b1, 8'hD9, 2'b10, 1'b0, '0);
        pop(2'b01);
        drained("R3 flush");

        // R3 flush abandons pending addressing byte
        fetch(8'hD9);
        exp_esc++; pop(2'b01);
        pop(2'b10);
        fetch(8'hC0);
        pop(2'b11);
        drained("R3 flush pending");

        // R9 new first byte restarts decode
        fetch(8'hD9); fetch(8'hDA); fetch(8'h06);
        exp_esc++; pop(2'b01);
        exp_esc++; pop(2'b01);
        exp_op.push_back({1'b1, 11'h206}); pop(2'b11);
        // R9 new first byte cancels operand capture
        fetch(8'h90);
        pop(2'b01);
        opr_read(20'h55555);
        drained("R9 restart and cancel");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule